// File: doc/BRIEF.md
# Message Interrupt Remapping Unit

This block sits between the devices that signal interrupts by message writes and the interrupt delivery side of the processors. An incoming message says only which device sent it (a 16-bit requester ID) and which of that device's interrupts fired (an 8-bit message identifier). It carries neither a vector nor a destination. The block resolves the requester ID through a per-device context table to a window of a remapping table. It reads the selected remapping entry, checks that the entry is present and belongs to the sender, and then presents the vector and the destination processor on a valid/ready delivery port.

Both tables are loaded by the hypervisor through a simple write port. Fetched remapping entries are kept in a small direct-mapped cache. Writing a table does not touch the cache, so software must issue an invalidate, either for one table address or for all of them, before a changed entry takes effect. A message that fails any check is dropped, and a one-cycle fault record is produced with a reason code, the requester ID and the identifier. Messages that arrive while a lookup is in flight wait in a two-entry queue.

Top module: `irq_remap_unit`

## Requirements
- R1: A message is accepted on a cycle where `msg_valid` and `msg_ready` are both high. Up to QDEPTH (2) accepted messages wait behind the one being resolved, and `msg_ready` is low while that queue is full.
- R2: The context slot is the low CTX_AW bits of the requester ID. A context word holds valid in bit 0, table base in bits 15:8 and the last legal identifier in bits 23:16. A message whose slot is not valid produces fault code 1 and no delivery.
- R3: An identifier greater than the slot's last legal identifier produces fault code 2. An identifier equal to it is looked up normally.
- R4: The remapping table address is (base + identifier) modulo 2^IRT_AW. An entry holds present in bit 0, vector in bits 15:8, destination in bits 23:16 and the permitted requester ID in bits 63:48. A passing lookup delivers that vector and that destination.
- R5: An entry whose present bit is 0 produces fault code 3 and no delivery.
- R6: An entry whose permitted requester ID differs from the sender's produces fault code 4 and no delivery.
- R7: A fault is a one-cycle pulse on `fault_valid`, carrying the code, the requester ID and the identifier of the failed message. It is never high at the same time as `dlv_valid`.
- R8: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid`, `dlv_vector` and `dlv_dest` hold their values.
- R9: A fetched entry is cached by table address (set = low bits of the address), and later lookups of that address use the cached copy. A table write does not change the cache. A fetch that lands in the same set replaces the older copy.
- R10: An invalidate with `inv_all` low drops the cached copy of `inv_addr`, so the next lookup of that address reads the table.
- R11: An invalidate with `inv_all` high drops every cached copy.
- R12: Messages are delivered in the order they were accepted.
- R13: After reset `dlv_valid` and `fault_valid` are low, `msg_ready` is high, and the cache holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Interrupt message offered |
| msg_ready | output | 1 | Queue can take a message |
| msg_rid | input | 16 | Requester ID of the sending device |
| msg_id | input | 8 | Message identifier |
| dlv_valid | output | 1 | Remapped interrupt offered |
| dlv_ready | input | 1 | Delivery side takes the interrupt |
| dlv_vector | output | 8 | Interrupt vector |
| dlv_dest | output | 8 | Destination processor ID |
| fault_valid | output | 1 | One-cycle fault record |
| fault_code | output | 3 | Fault reason: 1 no context, 2 out of range, 3 not present, 4 source mismatch |
| fault_rid | output | 16 | Requester ID of the faulting message |
| fault_id | output | 8 | Identifier of the faulting message |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 writes the context table, 1 the remapping table |
| cfg_addr | input | IRT_AW | Table address (low CTX_AW bits for the context table) |
| cfg_wdata | input | 64 | Write data (low 32 bits for the context table) |
| inv_en | input | 1 | Cache invalidate strobe |
| inv_all | input | 1 | Invalidate every cached entry |
| inv_addr | input | IRT_AW | Remapping table address to invalidate |

## Verification
The bench builds the block with CTX_AW = 2, IRT_AW = 8 and CACHE_SETS = 2, keeping QDEPTH at 2. With only two cache sets, two table addresses of equal parity share a set, so eviction by a conflicting fetch can be provoked with a handful of messages. The full 8-bit table address lets a base near the top of the table wrap around to address 1. Four context slots are enough to place a valid slot, an invalid slot and a wrapping slot side by side. A two-deep queue fills after three back-to-back messages while delivery is stalled, which makes the backpressure and the ordering of queued messages visible at the ports.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
  localparam int RID_W = 16;
  localparam int MID_W = 8;
  localparam int ENT_W = 64;
  localparam int CTX_W = 32;

  typedef struct packed {
    logic [RID_W-1:0] rid;
    logic [MID_W-1:0] mid;
  } irq_msg_t;

  localparam int MSG_W = $bits(irq_msg_t);

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_NO_CTX = 3'd1,
    FLT_RANGE  = 3'd2,
    FLT_ABSENT = 3'd3,
    FLT_SRC    = 3'd4
  } flt_code_e;
endpackage

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         out_nempty,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push;

  assign in_ready   = (cnt != CW'(DEPTH));
  assign out_nempty = (cnt != '0);
  assign out_data   = slot[rp];
  assign push       = in_valid && in_ready;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        slot[wp] <= in_data;
        wp       <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  // R1: occupancy never exceeds the queue depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R12: the consumer never takes from an empty queue
  a_r12_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0);
endmodule

// File: rtl/irq_remap_tables.sv
module irq_remap_tables #(
  parameter int CTX_AW = 4,
  parameter int IRT_AW = 8
) (
  input  logic              clk,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IRT_AW-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  input  logic              ctx_re,
  input  logic [CTX_AW-1:0] ctx_addr,
  output logic [31:0]       ctx_q,
  input  logic              irt_re,
  input  logic [IRT_AW-1:0] irt_addr,
  output logic [63:0]       irt_q
);
  localparam int CTX_DEPTH = 1 << CTX_AW;
  localparam int IRT_DEPTH = 1 << IRT_AW;

  logic [31:0] ctx_mem [CTX_DEPTH];
  logic [63:0] irt_mem [IRT_DEPTH];

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_sel) ctx_mem[cfg_addr[CTX_AW-1:0]] <= cfg_wdata[31:0];
    if (ctx_re) ctx_q <= ctx_mem[ctx_addr];
  end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel) irt_mem[cfg_addr] <= cfg_wdata;
    if (irt_re) irt_q <= irt_mem[irt_addr];
  end
endmodule

// File: rtl/irq_remap_cache.sv
module irq_remap_cache #(
  parameter int SETS = 4,
  parameter int AW   = 8,
  parameter int DW   = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          inv_en,
  input  logic          inv_all,
  input  logic [AW-1:0] inv_addr
);
  localparam int SW = $clog2(SETS);

  logic [SETS-1:0] set_valid;
  logic [AW-1:0]   set_tag  [SETS];
  logic [DW-1:0]   set_data [SETS];
  logic [SETS-1:0] kill, load;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    assign kill[g] = inv_en && (inv_all || (set_tag[g] == inv_addr));
    assign load[g] = fill_en && (fill_addr[SW-1:0] == SW'(g)) && !kill[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_valid <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (kill[s])      set_valid[s] <= 1'b0;
        else if (load[s]) set_valid[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (load[s]) begin
        set_tag[s]  <= fill_addr;
        set_data[s] <= fill_data;
      end
    end
  end

  logic [SW-1:0] lk_set, inv_set;
  assign lk_set  = lk_addr[SW-1:0];
  assign inv_set = inv_addr[SW-1:0];
  assign lk_hit  = set_valid[lk_set] && (set_tag[lk_set] == lk_addr);
  assign lk_data = set_data[lk_set];

  // R11: a global invalidate leaves nothing cached
  a_r11_flush_all: assert property (@(posedge clk) disable iff (rst)
    inv_en && inv_all |=> set_valid == '0);
  // R10: a single invalidate leaves no valid copy of that address
  a_r10_flush_one: assert property (@(posedge clk) disable iff (rst)
    inv_en && !inv_all |=>
      !(set_valid[$past(inv_set)] && set_tag[$past(inv_set)] == $past(inv_addr)));
endmodule

// File: rtl/irq_remap_unit.sv
module irq_remap_unit
  import irq_remap_pkg::*;
#(
  parameter int CTX_AW     = 4,
  parameter int IRT_AW     = 8,
  parameter int CACHE_SETS = 4,
  parameter int QDEPTH     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [15:0]       msg_rid,
  input  logic [7:0]        msg_id,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [7:0]        dlv_vector,
  output logic [7:0]        dlv_dest,
  output logic              fault_valid,
  output logic [2:0]        fault_code,
  output logic [15:0]       fault_rid,
  output logic [7:0]        fault_id,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IRT_AW-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  input  logic              inv_en,
  input  logic              inv_all,
  input  logic [IRT_AW-1:0] inv_addr
);
  typedef enum logic [2:0] {S_IDLE, S_CTX, S_MEM, S_CHK, S_OUT} st_e;

  st_e              st;
  irq_msg_t         q_head, cur;
  logic [MSG_W-1:0] q_raw;
  logic             q_nempty, pop;
  logic [31:0]      ctx_q;
  logic [63:0]      irt_q, entry_r, c_data;
  logic             c_hit;
  logic [IRT_AW-1:0] irt_addr_c, irt_addr_r;
  logic [7:0]       ctx_base, ctx_limit, sum;

  assign q_head = irq_msg_t'(q_raw);
  assign pop    = (st == S_IDLE) && q_nempty;

  irq_msg_fifo #(.DEPTH(QDEPTH), .W(MSG_W)) u_q (
    .clk(clk), .rst(rst),
    .in_valid(msg_valid), .in_ready(msg_ready), .in_data({msg_rid, msg_id}),
    .pop(pop), .out_nempty(q_nempty), .out_data(q_raw)
  );

  assign ctx_base   = ctx_q[15:8];
  assign ctx_limit  = ctx_q[23:16];
  assign sum        = ctx_base + cur.mid;
  assign irt_addr_c = sum[IRT_AW-1:0];

  irq_remap_tables #(.CTX_AW(CTX_AW), .IRT_AW(IRT_AW)) u_tbl (
    .clk(clk),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ctx_re(pop), .ctx_addr(q_head.rid[CTX_AW-1:0]), .ctx_q(ctx_q),
    .irt_re(st == S_CTX), .irt_addr(irt_addr_c), .irt_q(irt_q)
  );

  irq_remap_cache #(.SETS(CACHE_SETS), .AW(IRT_AW), .DW(64)) u_cache (
    .clk(clk), .rst(rst),
    .lk_addr(irt_addr_c), .lk_hit(c_hit), .lk_data(c_data),
    .fill_en(st == S_MEM), .fill_addr(irt_addr_r), .fill_data(irt_q),
    .inv_en(inv_en), .inv_all(inv_all), .inv_addr(inv_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      dlv_valid   <= 1'b0;
      dlv_vector  <= '0;
      dlv_dest    <= '0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      fault_rid   <= '0;
      fault_id    <= '0;
    end else begin
      fault_valid <= 1'b0;
      case (st)
        S_IDLE: if (q_nempty) begin
          cur <= q_head;
          st  <= S_CTX;
        end
        S_CTX: begin
          if (!ctx_q[0] || cur.mid > ctx_limit) begin
            fault_valid <= 1'b1;
            fault_code  <= !ctx_q[0] ? FLT_NO_CTX : FLT_RANGE;
            fault_rid   <= cur.rid;
            fault_id    <= cur.mid;
            st          <= S_IDLE;
          end else begin
            irt_addr_r <= irt_addr_c;
            if (c_hit) begin
              entry_r <= c_data;
              st      <= S_CHK;
            end else begin
              st <= S_MEM;
            end
          end
        end
        S_MEM: begin
          entry_r <= irt_q;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (!entry_r[0] || entry_r[63:48] != cur.rid) begin
            fault_valid <= 1'b1;
            fault_code  <= !entry_r[0] ? FLT_ABSENT : FLT_SRC;
            fault_rid   <= cur.rid;
            fault_id    <= cur.mid;
            st          <= S_IDLE;
          end else begin
            dlv_valid  <= 1'b1;
            dlv_vector <= entry_r[15:8];
            dlv_dest   <= entry_r[23:16];
            st         <= S_OUT;
          end
        end
        S_OUT: if (dlv_ready) begin
          dlv_valid <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: an offered interrupt is held unchanged until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_dest));
  // R7: a fault record lasts exactly one cycle
  a_r7_fault_pulse: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);
  // R7: a fault and an offered delivery never coexist
  a_r7_excl: assert property (@(posedge clk) disable iff (rst)
    !(fault_valid && dlv_valid));
  // R7: every fault record carries a reason
  a_r7_coded: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> fault_code != 3'd0);
endmodule

// File: tb/sim_irq_remap_unit.sv
module sim_irq_remap_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        msg_valid = 1'b0, msg_ready;
  logic [15:0] msg_rid = '0;
  logic [7:0]  msg_id = '0;
  logic        dlv_valid, dlv_ready = 1'b1;
  logic [7:0]  dlv_vector, dlv_dest;
  logic        fault_valid;
  logic [2:0]  fault_code;
  logic [15:0] fault_rid;
  logic [7:0]  fault_id;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        inv_en = 1'b0, inv_all = 1'b0;
  logic [7:0]  inv_addr = '0;

  irq_remap_unit #(.CTX_AW(2), .IRT_AW(8), .CACHE_SETS(2), .QDEPTH(2)) u0 (.*);

  int n_tests = 0, n_fail = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctx(input int slot, input logic v, input logic [7:0] base, input logic [7:0] lim);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 8'(slot);
    cfg_wdata = {32'h0, 8'h0, lim, base, 7'h0, v};
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_irt(input logic [7:0] a, input logic p, input logic [7:0] vec,
                        input logic [7:0] dst, input logic [15:0] src);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = a;
    cfg_wdata = {src, 24'h0, dst, vec, 7'h0, p};
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic invalidate(input logic all, input logic [7:0] a);
    inv_en = 1'b1; inv_all = all; inv_addr = a;
    @(negedge clk); inv_en = 1'b0; inv_all = 1'b0;
  endtask

  task automatic send(input logic [15:0] rid, input logic [7:0] id);
    msg_valid = 1'b1; msg_rid = rid; msg_id = id;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  // waits for either a delivery or a fault; is_dlv tells which
  task automatic result(output logic is_dlv, output logic [7:0] vec, output logic [7:0] dst,
                        output logic [2:0] fc, output logic [15:0] frid, output logic [7:0] fid,
                        output logic got);
    got = 1'b0; is_dlv = 1'b0; vec = '0; dst = '0; fc = '0; frid = '0; fid = '0;
    for (int i = 0; i < 100 && !got; i++) begin
      if (dlv_valid) begin
        got = 1'b1; is_dlv = 1'b1; vec = dlv_vector; dst = dlv_dest;
      end else if (fault_valid) begin
        got = 1'b1; fc = fault_code; frid = fault_rid; fid = fault_id;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_dlv(input string req, input logic [15:0] rid, input logic [7:0] id,
                            input logic [7:0] evec, input logic [7:0] edst);
    logic d, g; logic [7:0] v, t, fi; logic [2:0] c; logic [15:0] fr;
    send(rid, id);
    result(d, v, t, c, fr, fi, g);
    chk(g && d, req, {31'h0, d}, 1);
    chk(v == evec && t == edst, req, {16'h0, v, t}, {16'h0, evec, edst});
  endtask

  task automatic expect_flt(input string req, input logic [15:0] rid, input logic [7:0] id,
                            input logic [2:0] ecode);
    logic d, g; logic [7:0] v, t, fi; logic [2:0] c; logic [15:0] fr;
    send(rid, id);
    result(d, v, t, c, fr, fi, g);
    chk(g && !d && c == ecode, req, {28'h0, d, c}, {29'h0, ecode});
    chk(fr == rid && fi == id, {req, "/R7"}, {8'h0, fr, fi}, {8'h0, rid, id});
  endtask

  task automatic t_reset;
    chk(!dlv_valid && !fault_valid && msg_ready, "R13",
        {29'h0, dlv_valid, fault_valid, msg_ready}, 1);
  endtask

  task automatic t_setup;
    wr_ctx(0, 1'b0, 8'h00, 8'h00);
    wr_ctx(1, 1'b1, 8'h10, 8'h07);
    wr_ctx(2, 1'b0, 8'h20, 8'h07);
    wr_ctx(3, 1'b1, 8'hFC, 8'h09);
    wr_irt(8'h12, 1'b1, 8'h41, 8'h03, 16'h0101);
    wr_irt(8'h01, 1'b1, 8'h77, 8'h09, 16'h0203);
    wr_irt(8'h17, 1'b1, 8'h55, 8'h02, 16'h0101);
    wr_irt(8'h13, 1'b0, 8'h66, 8'h01, 16'h0101);
    wr_irt(8'h14, 1'b1, 8'h68, 8'h01, 16'h0105);
    wr_irt(8'h10, 1'b1, 8'h60, 8'h04, 16'h0101);
  endtask

  task automatic t_cache;
    expect_dlv("R4", 16'h0101, 8'd2, 8'h41, 8'h03);
    wr_irt(8'h12, 1'b1, 8'h42, 8'h03, 16'h0101);
    expect_dlv("R9 stale copy kept", 16'h0101, 8'd2, 8'h41, 8'h03);
    invalidate(1'b0, 8'h10);
    expect_dlv("R10 other address kept", 16'h0101, 8'd2, 8'h41, 8'h03);
    invalidate(1'b0, 8'h12);
    expect_dlv("R10 single invalidate", 16'h0101, 8'd2, 8'h42, 8'h03);
    wr_irt(8'h12, 1'b1, 8'h43, 8'h03, 16'h0101);
    expect_dlv("R9 conflict fetch", 16'h0101, 8'd0, 8'h60, 8'h04);
    expect_dlv("R9 evicted reread", 16'h0101, 8'd2, 8'h43, 8'h03);
    wr_irt(8'h12, 1'b1, 8'h44, 8'h05, 16'h0101);
    invalidate(1'b1, 8'h00);
    expect_dlv("R11 invalidate all", 16'h0101, 8'd2, 8'h44, 8'h05);
  endtask

  task automatic t_wrap;
    expect_dlv("R4 base wrap", 16'h0203, 8'd5, 8'h77, 8'h09);
  endtask

  task automatic t_faults;
    expect_flt("R2", 16'h0202, 8'd1, 3'd1);
    expect_flt("R3", 16'h0101, 8'd8, 3'd2);
    expect_dlv("R3 limit", 16'h0101, 8'd7, 8'h55, 8'h02);
    expect_flt("R5", 16'h0101, 8'd3, 3'd3);
    expect_flt("R6", 16'h0101, 8'd4, 3'd4);
    expect_dlv("R6 owner", 16'h0105, 8'd4, 8'h68, 8'h01);
  endtask

  task automatic t_hold;
    logic ok = 1'b1;
    dlv_ready = 1'b0;
    send(16'h0101, 8'd7);
    for (int i = 0; i < 20 && !dlv_valid; i++) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (!dlv_valid || dlv_vector != 8'h55 || dlv_dest != 8'h02) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R8", {16'h0, dlv_vector, dlv_dest}, 32'h5502);
    dlv_ready = 1'b1;
    @(negedge clk);
    chk(!dlv_valid, "R8 taken", {31'h0, dlv_valid}, 0);
  endtask

  task automatic t_queue;
    logic d, g; logic [7:0] v, t, fi; logic [2:0] c; logic [15:0] fr;
    logic [7:0] ev [3] = '{8'h44, 8'h60, 8'h55};
    dlv_ready = 1'b0;
    send(16'h0101, 8'd2);
    send(16'h0101, 8'd0);
    send(16'h0101, 8'd7);
    repeat (6) @(negedge clk);
    chk(!msg_ready, "R1 full", {31'h0, msg_ready}, 0);
    dlv_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      result(d, v, t, c, fr, fi, g);
      chk(g && d && v == ev[k], "R12 order", {24'h0, v}, {24'h0, ev[k]});
    end
    chk(msg_ready, "R1 drained", {31'h0, msg_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_cache();
    t_wrap();
    t_faults();
    t_hold();
    t_queue();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule